// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit logical address into a 16-bit physical address through a small table of four segments. The two most significant address bits pick a table entry. The remaining twelve bits are an offset. That offset is added to the entry's base and, at the same time, compared against the entry's last legal offset. A two-bit permission field gates reads and writes.

Software fills the table through a one-entry-per-cycle write port. Each translation request carries an address and a direction flag. The response appears exactly one clock later and holds either a physical address or a fault cause. After reset every entry is unusable, so nothing translates until software has loaded the table.

Top module: `seg_xlate`

## Requirements
- R1: A response (`rsp_valid` high) appears on the clock edge after the edge that captured `req_valid` high, and only then. While `rsp_valid` is low, `rsp_paddr` and `rsp_fault` are zero.
- R2: Logical address bits 13:12 select the table entry, and bits 11:0 form the offset.
- R3: On success, `rsp_paddr` equals the entry base plus the zero-extended offset, modulo 2^16, and `rsp_fault` is 2'b00.
- R4: The limit field is the last legal offset. An offset above the limit gives `rsp_fault` = 2'b01 (bounds), and an offset equal to the limit succeeds.
- R5: Permission bit 1 allows reads and bit 0 allows writes (`req_write` = 1 means write). An access whose direction bit is clear gives `rsp_fault` = 2'b10 (protection).
- R6: An entry whose permission field is 2'b00 faults with protection on every access.
- R7: When an access violates both permission and bounds, the reported cause is protection (2'b10).
- R8: Whenever `rsp_fault` is non-zero, `rsp_paddr` is zero.
- R9: After reset every entry has permission 2'b00, so every access faults with protection until the table is written.
- R10: A table write and a request in the same cycle are resolved so that the request uses the entry as it was before the write. Requests from the next cycle onward use the new contents.
- R11: A write with `tbl_we` high stores `tbl_base`, `tbl_limit` and `tbl_perm` into the entry selected by `tbl_idx` and leaves the other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 2 | Entry selected for the write |
| tbl_base | input | 16 | Base physical address to store |
| tbl_limit | input | 12 | Last legal offset to store |
| tbl_perm | input | 2 | Permission bits to store: bit 1 read, bit 0 write |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 14 | Logical address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 bounds, 10 protection |

## Verification
A corrupted table entry changes the answer to the first request that selects it. The wrong address or fault code shows up one clock after that request. The bench therefore reads back every entry through translations that sit exactly on the limit and one past it, in both directions. A stale or premature entry write is caught because a request issued in the same cycle as a write must still see the old permissions.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BOUNDS = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  localparam int PERM_W     = 2;
  localparam int PERM_RD_IX = 1;
  localparam int PERM_WR_IX = 0;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/seg_entry.sv
module seg_entry
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int LIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  input  logic [PERM_W-1:0] ld_perm,
  output logic [BASE_W-1:0] base_q,
  output logic [LIM_W-1:0]  limit_q,
  output logic [PERM_W-1:0] perm_q
);

  logic [BASE_W-1:0] base_d;
  logic [LIM_W-1:0]  limit_d;
  logic [PERM_W-1:0] perm_d;

  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    perm_d  = perm_q;
    if (ld_en) begin
      base_d  = ld_base;
      limit_d = ld_limit;
      perm_d  = ld_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      perm_q  <= '0;
    end else begin
      base_q  <= base_d;
      limit_q <= limit_d;
      perm_q  <= perm_d;
    end
  end

  // R11
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (base_q == $past(ld_base)) && (limit_q == $past(ld_limit)) &&
              (perm_q == $past(ld_perm)));

  // R11
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(base_q) && $stable(limit_q) && $stable(perm_q));

endmodule

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 2,
  parameter int BASE_W = 16,
  parameter int LIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic [PERM_W-1:0] rd_perm
);

  localparam int NSEG = 1 << SEG_W;

  logic [BASE_W-1:0] ent_base  [NSEG];
  logic [LIM_W-1:0]  ent_limit [NSEG];
  logic [PERM_W-1:0] ent_perm  [NSEG];

  for (genvar gi = 0; gi < NSEG; gi++) begin : g_ent
    logic sel_en;
    assign sel_en = wr_en && (wr_idx == SEG_W'(gi));

    seg_entry #(
      .BASE_W (BASE_W),
      .LIM_W  (LIM_W)
    ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (sel_en),
      .ld_base  (wr_base),
      .ld_limit (wr_limit),
      .ld_perm  (wr_perm),
      .base_q   (ent_base[gi]),
      .limit_q  (ent_limit[gi]),
      .perm_q   (ent_perm[gi])
    );
  end

  // Reads come straight from the stored state, so a same-cycle write is not seen.
  always_comb begin
    rd_base  = ent_base[rd_idx];
    rd_limit = ent_limit[rd_idx];
    rd_perm  = ent_perm[rd_idx];
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int OFF_W  = 12
) (
  input  logic [BASE_W-1:0] base,
  input  logic [OFF_W-1:0]  limit,
  input  logic [PERM_W-1:0] perm,
  input  logic [OFF_W-1:0]  offset,
  input  logic              is_write,
  output logic [BASE_W-1:0] paddr,
  output fault_e            fault
);

  localparam int PAD_W = BASE_W - OFF_W;

  logic [BASE_W-1:0] sum;
  logic              over_lim;
  logic              no_right;

  // Adder and comparator side by side; neither waits on the other.
  always_comb begin
    sum      = base + {{PAD_W{1'b0}}, offset};
    over_lim = offset > limit;
    no_right = is_write ? !perm[PERM_WR_IX] : !perm[PERM_RD_IX];
  end

  always_comb begin
    if (no_right) begin
      fault = FLT_PROT;
      paddr = '0;
    end else if (over_lim) begin
      fault = FLT_BOUNDS;
      paddr = '0;
    end else begin
      fault = FLT_NONE;
      paddr = sum;
    end
  end

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
  import seg_xlate_pkg::*;
#(
  parameter int PADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PADDR_W-1:0] in_paddr,
  input  fault_e             in_fault,
  output logic               out_valid,
  output logic [PADDR_W-1:0] out_paddr,
  output logic [1:0]         out_fault
);

  logic               valid_d;
  logic [PADDR_W-1:0] paddr_d;
  logic [1:0]         fault_d;

  always_comb begin
    valid_d = in_valid;
    paddr_d = '0;
    fault_d = FLT_NONE;
    if (in_valid) begin
      paddr_d = in_paddr;
      fault_d = in_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_fault <= FLT_NONE;
    end else begin
      out_valid <= valid_d;
      out_paddr <= paddr_d;
      out_fault <= fault_d;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int LADDR_W = 14,
  parameter int SEG_W   = 2,
  parameter int PADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [SEG_W-1:0]   tbl_idx,
  input  logic [PADDR_W-1:0] tbl_base,
  input  logic [LADDR_W-SEG_W-1:0] tbl_limit,
  input  logic [1:0]         tbl_perm,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic [1:0]         rsp_fault
);

  localparam int OFF_W = LADDR_W - SEG_W;

  logic               rst_q_n;
  logic [SEG_W-1:0]   seg_sel;
  logic [OFF_W-1:0]   seg_off;
  logic [PADDR_W-1:0] sel_base;
  logic [OFF_W-1:0]   sel_limit;
  logic [PERM_W-1:0]  sel_perm;
  logic [PADDR_W-1:0] chk_paddr;
  fault_e             chk_fault;

  assign seg_sel = req_addr[LADDR_W-1 -: SEG_W];
  assign seg_off = req_addr[OFF_W-1:0];

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  seg_table #(
    .SEG_W  (SEG_W),
    .BASE_W (PADDR_W),
    .LIM_W  (OFF_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_base  (tbl_base),
    .wr_limit (tbl_limit),
    .wr_perm  (tbl_perm),
    .rd_idx   (seg_sel),
    .rd_base  (sel_base),
    .rd_limit (sel_limit),
    .rd_perm  (sel_perm)
  );

  seg_check #(
    .BASE_W (PADDR_W),
    .OFF_W  (OFF_W)
  ) u_check (
    .base     (sel_base),
    .limit    (sel_limit),
    .perm     (sel_perm),
    .offset   (seg_off),
    .is_write (req_write),
    .paddr    (chk_paddr),
    .fault    (chk_fault)
  );

  seg_resp_reg #(
    .PADDR_W (PADDR_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .in_valid  (req_valid),
    .in_paddr  (chk_paddr),
    .in_fault  (chk_fault),
    .out_valid (rsp_valid),
    .out_paddr (rsp_paddr),
    .out_fault (rsp_fault)
  );

  // R8
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rsp_valid |-> (rsp_paddr == '0) && (rsp_fault == FLT_NONE));

  // R6
  dead_seg_prot_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && (sel_perm == '0)) |=> (rsp_fault == FLT_PROT));

  // R5
  fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_valid |-> (rsp_fault != 2'b11));

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

  logic        clk;
  logic        rst_n;
  logic        tbl_we;
  logic [1:0]  tbl_idx;
  logic [15:0] tbl_base;
  logic [11:0] tbl_limit;
  logic [1:0]  tbl_perm;
  logic        req_valid;
  logic [13:0] req_addr;
  logic        req_write;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  seg_xlate dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl_we    (tbl_we),
    .tbl_idx   (tbl_idx),
    .tbl_base  (tbl_base),
    .tbl_limit (tbl_limit),
    .tbl_perm  (tbl_perm),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {addr[13:0], write, paddr[15:0], fault[1:0]}
  localparam int NV = 12;
  localparam logic [32:0] VECS [NV] = '{
    {14'h0240, 1'b0, 16'h4240, 2'b00},  // R3
    {14'h06ff, 1'b0, 16'h46ff, 2'b00},  // R4 on limit
    {14'h0700, 1'b0, 16'h0000, 2'b01},  // R4 past limit
    {14'h0240, 1'b1, 16'h0000, 2'b10},  // R5 read-only
    {14'h0800, 1'b1, 16'h0000, 2'b10},  // R7 both
    {14'h1108, 1'b0, 16'h0108, 2'b00},  // R2
    {14'h14ff, 1'b1, 16'h04ff, 2'b00},  // R4
    {14'h1500, 1'b1, 16'h0000, 2'b01},  // R4
    {14'h265c, 1'b0, 16'h365c, 2'b00},  // R2
    {14'h2fff, 1'b1, 16'h3fff, 2'b00},  // R3
    {14'h3002, 1'b0, 16'h0000, 2'b10},  // R6
    {14'h3002, 1'b1, 16'h0000, 2'b10}   // R6
  };

  task automatic check(input string tag, input logic [15:0] p, input logic [1:0] f,
                       input logic v);
    checks++;
    if (rsp_valid !== v || rsp_paddr !== p || rsp_fault !== f) begin
      errors++;
      $display("FAIL %s: got v=%b p=%h f=%b, expected v=%b p=%h f=%b",
               tag, rsp_valid, rsp_paddr, rsp_fault, v, p, f);
    end
  endtask

  task automatic load(input logic [1:0] i, input logic [15:0] b, input logic [11:0] l,
                      input logic [1:0] pm);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i; tbl_base = b; tbl_limit = l; tbl_perm = pm;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic xlate(input logic [13:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tbl_we = 1'b0; tbl_idx = '0; tbl_base = '0; tbl_limit = '0;
    tbl_perm = '0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R9: quiet after reset, then every entry faults with protection
    check("R1 idle after reset", 16'h0, 2'b00, 1'b0);
    for (int i = 0; i < 4; i++) begin
      xlate({i[1:0], 12'h000}, 1'b0);
      check("R9 empty table", 16'h0, 2'b10, 1'b1);
    end
    @(negedge clk);
    check("R1 no request no response", 16'h0, 2'b00, 1'b0);

    // R11: load table
    load(2'd0, 16'h4000, 12'h6ff, 2'b10);
    load(2'd1, 16'h0000, 12'h4ff, 2'b11);
    load(2'd2, 16'h3000, 12'hfff, 2'b11);

    for (int k = 0; k < NV; k++) begin
      xlate(VECS[k][32:19], VECS[k][18]);
      check($sformatf("R3/R4/R5 vector %0d", k), VECS[k][17:2], VECS[k][1:0], 1'b1);
    end

    // R10: same-cycle write and request sees the old entry
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'd3; tbl_base = 16'h8000; tbl_limit = 12'hfff;
    tbl_perm = 2'b11;
    req_valid = 1'b1; req_addr = 14'h3002; req_write = 1'b0;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    check("R10 old entry used", 16'h0, 2'b10, 1'b1);
    xlate(14'h3002, 1'b0);
    check("R10 new entry next cycle", 16'h8002, 2'b00, 1'b1);

    // R11: other entries untouched by that write
    xlate(14'h0240, 1'b0);
    check("R11 neighbour unchanged", 16'h4240, 2'b00, 1'b1);

    // R5: write-only entry
    load(2'd3, 16'h1000, 12'h0ff, 2'b01);
    xlate(14'h3010, 1'b0);
    check("R5 read on write-only", 16'h0, 2'b10, 1'b1);
    xlate(14'h3010, 1'b1);
    check("R5 write on write-only", 16'h1010, 2'b00, 1'b1);

    // R3: sum wraps modulo 2^16
    load(2'd3, 16'hf800, 12'hfff, 2'b11);
    xlate(14'h3fff, 1'b0);
    check("R3 wrap", 16'h07ff, 2'b00, 1'b1);

    // R4: limit zero allows only offset zero
    load(2'd1, 16'h2222, 12'h000, 2'b11);
    xlate(14'h1000, 1'b1);
    check("R4 zero limit at 0", 16'h2222, 2'b00, 1'b1);
    xlate(14'h1001, 1'b1);
    check("R4 zero limit at 1", 16'h0, 2'b01, 1'b1);

    // R9: reset again wipes the table
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xlate(14'h2000, 1'b0);
    check("R9 reset clears table", 16'h0, 2'b10, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule